// File: doc/BRIEF.md
# Strap-Addressed I2C Control Slave

This block is a two-wire serial bus slave that lets a host controller set one operating-mode register and read back a stream of status bytes. The clock and data lines are oversampled by the chip's system clock: each passes through a synchroniser, and edge and bus-condition detection run on the synchronised copies. The data line is open-drain. The block never drives it high. It only asserts an output enable that pulls the line low.

The slave answers to one of two 7-bit device addresses, chosen by a strap input. A write transfer carries exactly one payload byte, which lands in the control register and raises a one-cycle strobe. A read transfer streams bytes taken from an input byte port. The port is addressed by an index that restarts at zero on every START and steps forward after each acknowledge from the master. A non-matching address, a master NACK, or a surplus write byte sends the slave into a passive state until the next START or STOP.

Top module: `strap_i2c_slave`

## Requirements
- R1: After reset, sda_oe is 0, ctrl_q equals the CTRL_RESET parameter (default 0x00), ctrl_wr is 0 and rd_index is 0.
- R2: The address byte is the 7-bit device address followed by a direction bit (1 = read). With addr_sel = 0 the slave accepts 0x20 (write) and 0x21 (read). With addr_sel = 1 it accepts 0x22 (write) and 0x23 (read). It acknowledges a match by holding SDA low during the ninth SCL pulse.
- R3: A non-matching address byte is not acknowledged. Every following byte up to the next START or STOP is also not acknowledged, and ctrl_q does not change.
- R4: In a write transfer, the first byte after the address is loaded into ctrl_q and acknowledged.
- R5: Write bytes after the first are not acknowledged and leave ctrl_q unchanged.
- R6: In a read transfer, the slave sends rd_data MSB first, one bit per SCL pulse. It changes sda_oe only while SCL is low.
- R7: rd_index increments by one after each master ACK. A master NACK ends the read: after the NACK pulse the slave releases SDA and drives nothing more.
- R8: A repeated START received during a transfer clears rd_index to 0 and returns the slave to address reception.
- R9: ctrl_wr is high for exactly one system clock cycle per accepted write byte. A STOP releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Strap that selects the address pair |
| rd_data | input | DATA_W | Byte offered for reads at rd_index |
| rd_index | output | IDX_W | Index of the read byte being requested |
| ctrl_q | output | DATA_W | Operating-mode control register |
| ctrl_wr | output | 1 | One-cycle strobe when ctrl_q is written |

## Verification
Each synchronised line lags its pad by two clocks, and edge detection adds one more. So sda_oe and ctrl_q change three to four system clocks after the SCL edge that triggers them. An SCL half period lasts 16 clocks and the host model moves SDA a quarter period after each SCL fall, so every acknowledge and read bit is sampled at the middle of the SCL high phase, long after the slave has settled. ctrl_q, rd_index and the release of SDA are checked a full quarter period or more after the closing bus event. The count of ctrl_wr pulses and of high cycles is tallied on every clock edge and compared after each transfer.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } slv_state_e;

   // Device address with the strap folded into the lowest address bit
   function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic sel);
      return base | {6'b0, sel};
   endfunction

endpackage

// File: rtl/i2cps_sync.sv
module i2cps_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cps_bus_events.sv
module i2cps_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cps_proto.sv
module i2cps_proto
   import i2cps_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          IDX_W     = 4,
   parameter logic [6:0]  ADDR_BASE = 7'h10,
   parameter logic [7:0]  CTRL_RESET = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              sda_s,
   input  logic              addr_sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sda_oe,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              ctrl_wr,
   output logic [IDX_W-1:0]  rd_index
);
   localparam int CNT_W    = $clog2(DATA_W + 1);
   localparam int LAST_BIT = DATA_W - 1;

   slv_state_e        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              rw_bit;
   logic              got_byte;
   logic              master_ack;
   logic [6:0]        my_addr;
   logic              byte_done;

   assign my_addr   = dev_addr(ADDR_BASE, addr_sel);
   assign byte_done = (bit_cnt == CNT_W'(DATA_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         rw_bit     <= 1'b0;
         got_byte   <= 1'b0;
         master_ack <= 1'b0;
         sda_oe     <= 1'b0;
         ctrl_q     <= CTRL_RESET[DATA_W-1:0];
         ctrl_wr    <= 1'b0;
         rd_index   <= '0;
      end else begin
         ctrl_wr <= 1'b0;
         if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_evt) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_oe   <= 1'b0;
            rd_index <= '0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise && !byte_done) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && byte_done) begin
                     if (shreg[7:1] == my_addr) begin
                        rw_bit <= shreg[0];
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rw_bit) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[LAST_BIT];
                        state  <= ST_RD;
                     end else begin
                        sda_oe   <= 1'b0;
                        got_byte <= 1'b0;
                        state    <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise && !byte_done) begin
                     shreg   <= {shreg[DATA_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && byte_done) begin
                     if (!got_byte) begin
                        ctrl_q   <= shreg;
                        ctrl_wr  <= 1'b1;
                        got_byte <= 1'b1;
                        sda_oe   <= 1'b1;
                        state    <= ST_WR_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (bit_cnt == CNT_W'(LAST_BIT)) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_RD_ACK;
                     end else begin
                        shreg   <= {shreg[DATA_W-2:0], 1'b0};
                        sda_oe  <= ~shreg[LAST_BIT-1];
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     master_ack <= ~sda_s;
                     if (!sda_s) rd_index <= rd_index + 1'b1;
                  end else if (scl_fall) begin
                     if (master_ack) begin
                        shreg   <= rd_data;
                        sda_oe  <= ~rd_data[LAST_BIT];
                        bit_cnt <= '0;
                        state   <= ST_RD;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/strap_i2c_slave.sv
module strap_i2c_slave #(
   parameter int         DATA_W      = 8,
   parameter int         IDX_W       = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_BASE   = 7'h10,
   parameter logic [7:0] CTRL_RESET  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_index,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              ctrl_wr
);
   if (DATA_W != 8) begin : g_bad_width
      $error("DATA_W must be 8 for a byte-oriented bus");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_BASE[0] != 1'b0) begin : g_bad_base
      $error("ADDR_BASE bit 0 is reserved for the strap");
   end

   logic [1:0] pad_sync;
   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_evt;
   logic       stop_evt;

   i2cps_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (pad_sync)
   );

   assign scl_s = pad_sync[1];
   assign sda_s = pad_sync[0];

   i2cps_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2cps_proto #(
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W),
      .ADDR_BASE  (ADDR_BASE),
      .CTRL_RESET (CTRL_RESET)
   ) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .sda_s     (sda_s),
      .addr_sel  (addr_sel),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .ctrl_q    (ctrl_q),
      .ctrl_wr   (ctrl_wr),
      .rd_index  (rd_index)
   );
endmodule

// File: rtl/i2cps_chk.sv
module i2cps_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe,
   input logic [DATA_W-1:0] ctrl_q,
   input logic              ctrl_wr,
   input logic              start_evt,
   input logic              stop_evt,
   input logic [IDX_W-1:0]  rd_index
);
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s); // R6

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !ctrl_wr); // R9

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |-> $stable(ctrl_q)); // R5

   AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (rd_index == '0)); // R8

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe); // R9

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_index != $past(rd_index)) |->
         ((rd_index == IDX_W'($past(rd_index) + 1'b1)) || (rd_index == '0))); // R7
endmodule

bind strap_i2c_slave i2cps_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_oe    (sda_oe),
   .ctrl_q    (ctrl_q),
   .ctrl_wr   (ctrl_wr),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .rd_index  (rd_index)
);

// File: tb/strap_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module strap_i2c_slave_tb_top;
   localparam int H = 16;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       addr_sel = 1'b0;
   logic       sda_oe;
   logic       sda_line;
   logic [7:0] rd_data;
   logic [3:0] rd_index;
   logic [7:0] ctrl_q;
   logic       ctrl_wr;

   int checks = 0;
   int errors = 0;
   int wr_pulses = 0;
   int wr_high = 0;
   int oe_bad = 0;
   logic wr_prev = 1'b0;
   logic oe_prev = 1'b0;
   logic [7:0] exp_ctrl = 8'h00;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   function automatic logic [7:0] rd_fn(input logic [3:0] i);
      return (8'({4'b0, i}) * 8'h37) ^ 8'hA5;
   endfunction

   function automatic logic [7:0] addr_byte(input logic sel, input logic rw);
      return 8'h20 | {6'b0, sel, 1'b0} | {7'b0, rw};
   endfunction

   assign rd_data = rd_fn(rd_index);

   strap_i2c_slave dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .addr_sel (addr_sel),
      .rd_data  (rd_data),
      .rd_index (rd_index),
      .ctrl_q   (ctrl_q),
      .ctrl_wr  (ctrl_wr)
   );

   always @(posedge clk) begin
      if (ctrl_wr) wr_high++;
      if (ctrl_wr && !wr_prev) wr_pulses++;
      wr_prev <= ctrl_wr;
      if (rst_n && (sda_oe != oe_prev) && scl_m) oe_bad++;
      oe_prev <= sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      hold(Q); sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(H);
      sda_m = 1'b0; hold(H); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      hold(Q); sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(H);
      sda_m = 1'b1; hold(H);
   endtask

   task automatic bus_bit(input logic b, output logic seen);
      hold(Q); sda_m = b; hold(Q); scl_m = 1'b1; hold(Q);
      seen = sda_line; hold(Q); scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(~give_ack, s);
   endtask

   task automatic do_write(input logic sel, input logic [7:0] data, input int extra);
      logic a;
      int p0 = wr_pulses;
      int h0 = wr_high;
      addr_sel = sel;
      bus_start();
      send_byte(addr_byte(sel, 1'b0), a);
      chk(a == 1'b1, "R2 write address ack", int'(a), 1);
      send_byte(data, a);
      chk(a == 1'b1, "R4 data byte ack", int'(a), 1);
      for (int k = 0; k < extra; k++) begin
         send_byte(data ^ 8'hFF, a);
         chk(a == 1'b0, "R5 extra byte nack", int'(a), 0);
      end
      bus_stop();
      hold(Q);
      exp_ctrl = data;
      chk(ctrl_q == exp_ctrl, "R4 ctrl_q value", int'(ctrl_q), int'(exp_ctrl));
      chk((wr_pulses - p0 == 1) && (wr_high - h0 == 1), "R9 ctrl_wr single cycle",
          wr_high - h0, 1);
      chk(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);
   endtask

   task automatic do_read(input logic sel, input int n);
      logic a;
      logic [7:0] d;
      addr_sel = sel;
      bus_start();
      send_byte(addr_byte(sel, 1'b1), a);
      chk(a == 1'b1, "R2 read address ack", int'(a), 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d);
         chk(d == rd_fn(4'(k)), "R6 read byte", int'(d), int'(rd_fn(4'(k))));
      end
      hold(Q);
      chk(rd_index == 4'(n - 1), "R7 index after acks", int'(rd_index), n - 1);
      chk(sda_oe == 1'b0, "R7 released after nack", int'(sda_oe), 0);
      bus_stop();
   endtask

   task automatic do_bad(input logic sel, input logic [7:0] abyte);
      logic a;
      addr_sel = sel;
      bus_start();
      send_byte(abyte, a);
      chk(a == 1'b0, "R3 foreign address nack", int'(a), 0);
      send_byte(8'h96, a);
      chk(a == 1'b0, "R3 following byte ignored", int'(a), 0);
      bus_stop();
      hold(Q);
      chk(ctrl_q == exp_ctrl, "R3 ctrl_q unchanged", int'(ctrl_q), int'(exp_ctrl));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      int unused_seed;
      unused_seed = $urandom(32'h5eed_1234);
      hold(10);
      rst_n = 1'b1;
      hold(4);
      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda_oe reset", int'(sda_oe), 0);
      chk(ctrl_q == 8'h00, "R1 ctrl_q reset", int'(ctrl_q), 0);
      chk(wr_high == 0, "R1 ctrl_wr reset", wr_high, 0);
      chk(rd_index == 4'd0, "R1 rd_index reset", int'(rd_index), 0);

      do_write(1'b0, 8'h5A, 0);
      do_bad(1'b1, addr_byte(1'b0, 1'b0));   // R3: other strap's address
      do_write(1'b1, 8'hC3, 1);               // R5: one extra byte
      do_read(1'b1, 3);                       // R6 R7
      do_bad(1'b0, 8'h40);

      // R8 repeated START mid transfer
      addr_sel = 1'b0;
      bus_start();
      send_byte(addr_byte(1'b0, 1'b1), a);
      recv_byte(1'b1, d);
      recv_byte(1'b0, d);
      hold(Q);
      chk(rd_index == 4'd1, "R7 index before restart", int'(rd_index), 1);
      bus_start();
      hold(Q);
      chk(rd_index == 4'd0, "R8 index cleared by restart", int'(rd_index), 0);
      send_byte(addr_byte(1'b0, 1'b0), a);
      chk(a == 1'b1, "R8 address after restart acked", int'(a), 1);
      send_byte(8'h3C, a);
      chk(a == 1'b1, "R8 write after restart acked", int'(a), 1);
      bus_stop();
      hold(Q);
      exp_ctrl = 8'h3C;
      chk(ctrl_q == 8'h3C, "R8 ctrl_q after restart", int'(ctrl_q), 8'h3C);

      for (int it = 0; it < 24; it++) begin
         logic sel;
         int kind;
         sel  = 1'($urandom % 2);
         kind = int'($urandom % 3);
         if (kind == 0) begin
            do_write(sel, 8'($urandom), int'($urandom % 2));
         end else if (kind == 1) begin
            do_read(sel, 1 + int'($urandom % 4));
         end else begin
            logic [6:0] ba;
            ba = 7'($urandom);
            if (ba == (7'h10 | {6'b0, sel})) ba = ba ^ 7'h40;
            do_bad(sel, {ba, 1'($urandom)});
         end
      end

      chk(oe_bad == 0, "R6 sda_oe moved only with SCL low", oe_bad, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule